// File: doc/BRIEF.md
# Dual-Channel Capture/Compare Timer

This block adds two capture/compare channels to a free-running counter that lives elsewhere. The counter value, its overflow pulse and the stop and counter-reset controls come in as inputs. Each channel has a control/status byte and a 16-bit value register on a small byte-wide register bus. A channel can be off, can latch the counter value when its pin shows a chosen edge, or can act on its output pin when the counter matches its value. Each channel has an event flag and an interrupt enable. Its interrupt request is the AND of the two.

Software clears a flag in two steps. It reads the control byte while the flag is set, then writes 0 to the flag bit. If a new event arrives between the read and the write, the write leaves the flag set, so no event is lost. Channel 0 also has a buffered mode. In this mode channel 0 compares against the two channel value registers in turn, switching at each counter overflow. Channel 1 then goes inactive and hands its pin back to general-purpose I/O.

Top module: `cct_timer_pair`

## Requirements
- R1: Bus map: `bus_addr[2]` selects the channel. `bus_addr[1:0]` selects the register: 0 = control byte, 1 = value high byte, 2 = value low byte, 3 = reads 0. Control byte fields: bit 7 event flag, bit 6 interrupt enable, bit 5 buffered mode (channel 0 only, always reads 0 on channel 1), bit 4 mode select, bits 3:2 edge/action select, bits 1:0 read 0. After reset every register reads 0, `irq` = 0, `pin_own` = 0 and `cmp_out` = 2'b11.
- R2: Capture mode is edge/action select non-zero with mode select 0. A pin edge of the selected kind (01 rising, 10 falling, 11 either) copies `cnt_val` into the value register and sets the flag within 5 clocks, after a two-flop synchronizer. An edge of the other kind changes nothing.
- R3: Compare mode is edge/action select non-zero with mode select 1. While `tmr_stop` = 0, a cycle with `cnt_val` equal to the value register sets the flag and acts on `cmp_out` one clock later: 01 toggles it, 10 drives it low, 11 drives it high. While `tmr_stop` = 1 no match occurs.
- R4: Software reads the control byte while the flag is 1 and then writes it with bit 7 = 0. That write clears the flag.
- R5: A write of bit 7 = 0 with no flag-set read before it leaves the flag set. A write of bit 7 = 1 never changes the flag.
- R6: If a capture or compare event occurs after the arming read, the next write of bit 7 = 0 leaves the flag set.
- R7: `irq[i]` equals channel i's flag AND its interrupt enable.
- R8: Bits 5 and 4 change on a write only while `tmr_stop` and `tmr_clr` are both 1. Otherwise they hold, while bits 7, 6 and 3:2 of the same write still take effect.
- R9: With edge/action select = 00 the channel is inactive and `pin_own` = 0. `cmp_out` settles to low when mode select is 1 and to high when it is 0.
- R10: With channel 0 buffered mode on and its edge/action select non-zero, channel 0 compares against a value loaded at each `cnt_ovf` pulse. The first load after buffered mode is entered takes channel 0's register, and later loads alternate with channel 1's register. Channel 1 has no events, `pin_own[1]` = 0 and `irq[1]` = 0.
- R11: In buffered mode, a value written to a value register reaches the compare only at a later overflow that loads that register. The value currently in use stays active until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Current counter value |
| cnt_ovf | input | 1 | One-cycle pulse at counter overflow |
| tmr_stop | input | 1 | Counter stopped |
| tmr_clr | input | 1 | Counter held in reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_addr | input | 3 | Channel and register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cap_pin | input | 2 | Capture pins, asynchronous |
| cmp_out | output | 2 | Channel output levels |
| pin_own | output | 2 | 1 when the channel drives its pin |
| irq | output | 2 | Per-channel interrupt request |

## Verification
The hardest case to reach is an event landing between the arming read and the clearing write. The bench arms a flag with a read, then toggles the capture pin and waits out the synchronizer before it issues the write of 0. It then reads the byte back and expects the flag still set. Buffered mode is checked by pulsing matches against both stored values around overflow pulses. This shows that a value written while the timer runs only takes over at the next overflow that loads its register.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int FLAG_POS = 7;
    localparam int IE_POS   = 6;
    localparam int MB_POS   = 5;
    localparam int MA_POS   = 4;
    localparam int ELS_HI   = 3;
    localparam int ELS_LO   = 2;

    typedef enum logic [1:0] {
        FN_IDLE = 2'd0,
        FN_CAPT = 2'd1,
        FN_CMPR = 2'd2
    } chan_fn_e;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_HI   = 2'd1,
        REG_LO   = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       flag;
        logic       arm;
        logic       ie;
        logic       mb;
        logic       ma;
        logic [1:0] els;
        logic       lvl;
    } chan_st_t;

    function automatic chan_fn_e pick_fn(input logic [1:0] els, input logic ma, input logic mb);
        if (els == 2'b00) return FN_IDLE;
        else if (ma || mb) return FN_CMPR;
        else return FN_CAPT;
    endfunction
endpackage

// File: rtl/cct_edge_sync.sv
module cct_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int DW = STAGES + 1;

    logic [DW-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DW-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // newest synchronized sample against the one before it
    assign rise =  sh_q[DW-2] & ~sh_q[DW-1];
    assign fall = ~sh_q[DW-2] &  sh_q[DW-1];
endmodule

// File: rtl/cct_buf_sel.sv
module cct_buf_sel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ovf,
    input  logic [CW-1:0] val_a,
    input  logic [CW-1:0] val_b,
    output logic [CW-1:0] cur
);
    typedef struct packed {
        logic          pick_b;
        logic [CW-1:0] cur;
    } bsel_t;

    bsel_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.pick_b = 1'b0;
        end else if (ovf) begin
            st_d.cur    = st_q.pick_b ? val_b : val_a;
            st_d.pick_b = ~st_q.pick_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur = st_q.cur;
endmodule

// File: rtl/cct_chan.sv
module cct_chan
    import cct_pkg::*;
#(
    parameter int CW    = 16,
    parameter bit HAS_B = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic          rd_ctrl,
    input  logic [7:0]    wdata,
    input  logic          mode_ok,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic          rise,
    input  logic          fall,
    input  logic          suspend,
    input  logic [CW-1:0] buf_val,
    output logic [7:0]    ctrl_rd,
    output logic [CW-1:0] val,
    output logic          pin_lvl,
    output logic          pin_own,
    output logic          irq
);
    localparam logic [CW-1:0] LO_MASK = CW'(8'hFF);

    chan_st_t      st_d, st_q;
    logic [CW-1:0] val_d, val_q;
    chan_fn_e      fn;
    logic [CW-1:0] cmp_ref;
    logic          hit_cmp, hit_cap, evt;

    always_comb begin
        fn      = suspend ? FN_IDLE : pick_fn(st_q.els, st_q.ma, HAS_B & st_q.mb);
        cmp_ref = (HAS_B && st_q.mb) ? buf_val : val_q;
        hit_cmp = (fn == FN_CMPR) && run && (cnt == cmp_ref);
        hit_cap = (fn == FN_CAPT) && ((st_q.els[0] && rise) || (st_q.els[1] && fall));
        evt     = hit_cmp || hit_cap;

        st_d  = st_q;
        val_d = val_q;

        // a read arms the clear only if it saw the flag set
        if (rd_ctrl) st_d.arm = st_q.flag;

        if (wr_ctrl) begin
            st_d.ie  = wdata[IE_POS];
            st_d.els = wdata[ELS_HI:ELS_LO];
            if (mode_ok) begin
                st_d.ma = wdata[MA_POS];
                st_d.mb = HAS_B & wdata[MB_POS];
            end
            if (!wdata[FLAG_POS] && st_q.arm && !evt) st_d.flag = 1'b0;
            st_d.arm = 1'b0;
        end

        if (wr_hi) val_d = (val_q & LO_MASK) | (CW'(wdata) << 8);
        if (wr_lo) val_d = (val_q & ~LO_MASK) | CW'(wdata);
        if (hit_cap) val_d = cnt;

        // any new event wins over a pending clear and disarms it
        if (evt) begin
            st_d.flag = 1'b1;
            st_d.arm  = 1'b0;
        end

        if (st_q.els == 2'b00) begin
            st_d.lvl = ~st_q.ma;
        end else if (hit_cmp) begin
            case (st_q.els)
                2'b01:   st_d.lvl = ~st_q.lvl;
                2'b10:   st_d.lvl = 1'b0;
                default: st_d.lvl = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '{flag: 1'b0, arm: 1'b0, ie: 1'b0, mb: 1'b0, ma: 1'b0,
                       els: 2'b00, lvl: 1'b1};
            val_q <= '0;
        end else begin
            st_q  <= st_d;
            val_q <= val_d;
        end
    end

    assign ctrl_rd = {st_q.flag, st_q.ie, st_q.mb, st_q.ma, st_q.els, 2'b00};
    assign val     = val_q;
    assign pin_lvl = st_q.lvl;
    assign pin_own = !suspend && (st_q.els != 2'b00);
    assign irq     = st_q.flag && st_q.ie && !suspend;
endmodule

// File: rtl/cct_timer_pair.sv
module cct_timer_pair
    import cct_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_ovf,
    input  logic          tmr_stop,
    input  logic          tmr_clr,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic [1:0]    cap_pin,
    output logic [1:0]    cmp_out,
    output logic [1:0]    pin_own,
    output logic [1:0]    irq
);
    localparam int NCH = 2;

    reg_sel_e      rsel;
    logic          chi;
    logic          mode_ok;
    logic          lead_buf;
    logic [CW-1:0] buf_cur;
    logic [NCH-1:0] wr_ctrl, wr_hi, wr_lo, rd_ctrl, rise_w, fall_w;
    logic [7:0]    ch_ctrl [NCH];
    logic [CW-1:0] ch_val  [NCH];

    assign rsel     = reg_sel_e'(bus_addr[1:0]);
    assign chi      = bus_addr[2];
    assign mode_ok  = tmr_stop && tmr_clr;
    assign lead_buf = ch_ctrl[0][MB_POS];

    cct_buf_sel #(.CW(CW)) u_bsel (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (lead_buf),
        .ovf   (cnt_ovf),
        .val_a (ch_val[0]),
        .val_b (ch_val[1]),
        .cur   (buf_cur)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam bit IS_LEAD = (ch == 0);
        logic hit_ch;

        assign hit_ch      = bus_sel && (chi == 1'(ch));
        assign wr_ctrl[ch] = hit_ch && bus_wr && (rsel == REG_CTRL);
        assign wr_hi[ch]   = hit_ch && bus_wr && (rsel == REG_HI);
        assign wr_lo[ch]   = hit_ch && bus_wr && (rsel == REG_LO);
        assign rd_ctrl[ch] = hit_ch && bus_rd && (rsel == REG_CTRL);

        cct_edge_sync #(.STAGES(SYNC_STAGES)) u_es (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (cap_pin[ch]),
            .rise  (rise_w[ch]),
            .fall  (fall_w[ch])
        );

        cct_chan #(.CW(CW), .HAS_B(IS_LEAD)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_ctrl[ch]),
            .wr_hi   (wr_hi[ch]),
            .wr_lo   (wr_lo[ch]),
            .rd_ctrl (rd_ctrl[ch]),
            .wdata   (bus_wdata),
            .mode_ok (mode_ok),
            .run     (!tmr_stop),
            .cnt     (cnt_val),
            .rise    (rise_w[ch]),
            .fall    (fall_w[ch]),
            .suspend (IS_LEAD ? 1'b0 : lead_buf),
            .buf_val (buf_cur),
            .ctrl_rd (ch_ctrl[ch]),
            .val     (ch_val[ch]),
            .pin_lvl (cmp_out[ch]),
            .pin_own (pin_own[ch]),
            .irq     (irq[ch])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (rsel)
            REG_CTRL: bus_rdata = ch_ctrl[chi];
            REG_HI:   bus_rdata = 8'(ch_val[chi] >> 8);
            REG_LO:   bus_rdata = ch_val[chi][7:0];
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       tmr_stop,
    input logic       tmr_clr,
    input logic [7:0] ctrl0,
    input logic [7:0] ctrl1,
    input logic [1:0] pin_own,
    input logic [1:0] irq
);
    // R4
    flag0_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl0[7]) |-> $past(bus_sel && bus_wr && bus_addr == 3'd0 && !bus_wdata[7]));

    // R4
    flag1_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl1[7]) |-> $past(bus_sel && bus_wr && bus_addr == 3'd4 && !bus_wdata[7]));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl0[5:4]) |-> $past(tmr_stop && tmr_clr));

    // R8
    mode1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl1[4]) |-> $past(tmr_stop && tmr_clr));

    // R7
    irq0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> (ctrl0[7] && ctrl0[6]));

    // R7
    irq1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |-> (ctrl1[7] && ctrl1[6]));

    // R10
    buf_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl0[5] |-> (!pin_own[1] && !irq[1]));

    // R9
    idle_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl1[3:2] == 2'b00) |-> !pin_own[1]);
endmodule

bind cct_timer_pair cct_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tmr_stop  (tmr_stop),
    .tmr_clr   (tmr_clr),
    .ctrl0     (ch_ctrl[0]),
    .ctrl1     (ch_ctrl[1]),
    .pin_own   (pin_own),
    .irq       (irq)
);

// File: tb/sim_cct_timer_pair.sv
`timescale 1ns/100ps
module sim_cct_timer_pair;
    localparam logic [15:0] IDLE_CNT = 16'hF000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = IDLE_CNT;
    logic        cnt_ovf = 1'b0;
    logic        tmr_stop = 1'b1;
    logic        tmr_clr = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  cap_pin = 2'b00;
    logic [1:0]  cmp_out, pin_own, irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cct_timer_pair u0 (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
        .tmr_stop(tmr_stop), .tmr_clr(tmr_clr), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .cmp_out(cmp_out), .pin_own(pin_own), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, 16'(d), 16'(exp));
    endtask

    task automatic pulse_cnt(input logic [15:0] v);
        @(negedge clk); cnt_val = v;
        @(negedge clk); cnt_val = IDLE_CNT;
        #1;
    endtask

    task automatic pulse_ovf();
        @(negedge clk); cnt_ovf = 1'b1;
        @(negedge clk); cnt_ovf = 1'b0;
    endtask

    task automatic set_ctl(input logic stop, input logic clr);
        @(negedge clk); tmr_stop = stop; tmr_clr = clr;
    endtask

    task automatic set_pin(input int ch, input logic v);
        @(negedge clk); cap_pin[ch] = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 reset cmp_out", 16'(cmp_out), 16'h3);
        chk("R1 reset pin_own", 16'(pin_own), 16'h0);
        chk("R1 reset irq", 16'(irq), 16'h0);
        rd_chk("R1 reset ctrl0", 3'd0, 8'h00);
        rd_chk("R1 reset ctrl1", 3'd4, 8'h00);
        rd_chk("R1 reset val0 lo", 3'd2, 8'h00);
        rd_chk("R1 reset val1 hi", 3'd5, 8'h00);
    endtask

    task automatic t_mode_gate();
        set_ctl(1'b0, 1'b0);
        wr(3'd0, 8'h3C);
        rd_chk("R8 mode bits held while running", 3'd0, 8'h0C);
        set_ctl(1'b1, 1'b0);
        wr(3'd0, 8'h10);
        rd_chk("R8 mode bits held with stop only", 3'd0, 8'h00);
        set_ctl(1'b1, 1'b1);
        wr(3'd0, 8'h10);
        rd_chk("R8 mode bits written when stopped and cleared", 3'd0, 8'h10);
        wr(3'd4, 8'h20);
        rd_chk("R1 channel 1 buffered bit reads 0", 3'd4, 8'h00);
        repeat (2) @(negedge clk);
        #1;
        chk("R9 inactive pin not owned", 16'(pin_own[0]), 16'h0);
        chk("R9 inactive level low for mode 1", 16'(cmp_out[0]), 16'h0);
        chk("R9 inactive level high for mode 0", 16'(cmp_out[1]), 16'h1);
    endtask

    task automatic t_compare();
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h10);
        wr(3'd0, 8'h14);
        #1;
        chk("R3 pin owned in compare", 16'(pin_own[0]), 16'h1);
        chk("R3 level before match", 16'(cmp_out[0]), 16'h0);
        set_ctl(1'b0, 1'b0);
        pulse_cnt(16'h0010);
        chk("R3 toggle on match", 16'(cmp_out[0]), 16'h1);
        rd_chk("R3 flag on match", 3'd0, 8'h94);
        pulse_cnt(16'h000F);
        chk("R3 no action off match", 16'(cmp_out[0]), 16'h1);
        pulse_cnt(16'h0010);
        chk("R3 second toggle", 16'(cmp_out[0]), 16'h0);
        wr(3'd0, 8'h1C);
        pulse_cnt(16'h0010);
        chk("R3 set on match", 16'(cmp_out[0]), 16'h1);
        wr(3'd0, 8'h18);
        pulse_cnt(16'h0010);
        chk("R3 clear on match", 16'(cmp_out[0]), 16'h0);
        set_ctl(1'b1, 1'b0);
        rd_chk("R3 flag kept", 3'd0, 8'h98);
        wr(3'd0, 8'h18);
        wr(3'd0, 8'h1C);
        pulse_cnt(16'h0010);
        chk("R3 no match while stopped", 16'(cmp_out[0]), 16'h0);
        rd_chk("R3 no flag while stopped", 3'd0, 8'h1C);
    endtask

    task automatic t_capture();
        set_ctl(1'b1, 1'b1);
        wr(3'd4, 8'h04);
        cnt_val = 16'h1234;
        set_pin(1, 1'b1);
        rd_chk("R2 rising edge sets flag", 3'd4, 8'h84);
        rd_chk("R2 captured high byte", 3'd5, 8'h12);
        rd_chk("R2 captured low byte", 3'd6, 8'h34);
        wr(3'd4, 8'h04);
        rd_chk("R4 read then write 0 clears", 3'd4, 8'h04);
        cnt_val = 16'h5555;
        set_pin(1, 1'b0);
        rd_chk("R2 falling edge ignored in rising mode", 3'd4, 8'h04);
        rd_chk("R2 value kept on ignored edge", 3'd6, 8'h34);
        wr(3'd4, 8'h0C);
        cnt_val = 16'hABCD;
        set_pin(1, 1'b1);
        rd_chk("R2 either-edge capture low byte", 3'd6, 8'hCD);
        rd_chk("R2 either-edge flag", 3'd4, 8'h8C);
        cnt_val = IDLE_CNT;
    endtask

    task automatic t_clear();
        wr(3'd4, 8'hCC);
        wr(3'd4, 8'h4C);
        #1;
        chk("R7 irq with flag and enable", 16'(irq[1]), 16'h1);
        rd_chk("R5 write without read and write of 1 keep flag", 3'd4, 8'hCC);
        wr(3'd4, 8'h4C);
        #1;
        chk("R7 irq drops with flag", 16'(irq[1]), 16'h0);
        rd_chk("R4 armed clear", 3'd4, 8'h4C);
        set_pin(1, 1'b0);
        rd_chk("R6 flag set again", 3'd4, 8'hCC);
        set_pin(1, 1'b1);
        wr(3'd4, 8'h4C);
        rd_chk("R6 event between read and write keeps flag", 3'd4, 8'hCC);
        wr(3'd4, 8'h4C);
        rd_chk("R4 clear after fresh read", 3'd4, 8'h4C);
    endtask

    task automatic t_buffered();
        set_ctl(1'b1, 1'b1);
        wr(3'd2, 8'h20);
        wr(3'd5, 8'h00);
        wr(3'd6, 8'h30);
        wr(3'd4, 8'h44);
        wr(3'd0, 8'h34);
        #1;
        chk("R10 channel 1 pin released", 16'(pin_own[1]), 16'h0);
        rd_chk("R10 buffered mode set", 3'd0, 8'h34);
        set_ctl(1'b0, 1'b0);
        pulse_ovf();
        pulse_cnt(16'h0030);
        chk("R10 first load uses channel 0 value", 16'(cmp_out[0]), 16'h0);
        pulse_cnt(16'h0020);
        chk("R10 match on loaded value", 16'(cmp_out[0]), 16'h1);
        wr(3'd2, 8'h25);
        pulse_cnt(16'h0020);
        chk("R11 old value active before overflow", 16'(cmp_out[0]), 16'h0);
        pulse_ovf();
        pulse_cnt(16'h0030);
        chk("R10 alternates to channel 1 value", 16'(cmp_out[0]), 16'h1);
        pulse_ovf();
        pulse_cnt(16'h0020);
        chk("R11 stale value gone", 16'(cmp_out[0]), 16'h1);
        pulse_cnt(16'h0025);
        chk("R11 new value used after overflow", 16'(cmp_out[0]), 16'h0);
        set_pin(1, 1'b0);
        set_pin(1, 1'b1);
        chk("R10 channel 1 irq quiet", 16'(irq[1]), 16'h0);
        rd_chk("R10 channel 1 no event", 3'd4, 8'h44);
        rd_chk("R10 channel 1 value not captured", 3'd6, 8'h30);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode_gate();
        t_compare();
        t_capture();
        t_clear();
        t_buffered();
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule